// File: doc/BRIEF.md
# Peripheral Reset and Interrupt Control Port

This block is a single 8-bit control and status port on an 8-bit processor's I/O bus. It collects interrupt requests from two peripheral chips (an Ethernet controller with an active-low request pin and a USB host controller with an active-high request pin). Each request has its own enable. The enabled requests are combined into one aggregate flag. When software allows it, that flag pulls the processor's shared active-low interrupt line low. The same port also holds two software-controlled active-low reset outputs, one for each peripheral.

Software normally reads the port, changes the bits it cares about and writes the value back. Reads show the live, synchronized request bits next to the stored control bits, so this read-modify-write works. The bus side decodes one full 16-bit I/O address. A small two-state bus machine makes sure each write strobe loads the register exactly once.

Bus machine states: `ST_IDLE` (waiting for a write to the port) and `ST_WR_HOLD` (a write has been committed and the strobe is still active). Transitions: `ST_IDLE -> ST_WR_HOLD` on a decoded write strobe, with the commit on that clock edge. `ST_WR_HOLD -> ST_IDLE` when the decoded strobe goes away. Every other case stays in the current state.

Top module: `periph_irq_ctrl`

## Requirements
- R1: Read bit 0 shows the Ethernet request as active high, which is the inverse of `eth_int_n`. Read bit 1 shows `usb_irq`. Both pass through a two-flop synchronizer, so a change shows up in the read data after the second rising clock edge that follows it.
- R2: Write bits 3 and 2 are stored as enables and read back. Bit 2 enables the Ethernet request (bit 0) and bit 3 enables the USB request (bit 1).
- R3: Read bit 7 is 1 exactly when (bit0 AND bit2) OR (bit1 AND bit3). Writes to bits 7, 1 and 0 are ignored.
- R4: `cpu_int_n` is 0 only when stored bit 6 is 1 and read bit 7 is 1. Otherwise it is 1.
- R5: `eth_rst_n` equals stored bit 4 and `usb_rst_n` equals stored bit 5. Both change on the clock edge that commits the write.
- R6: After reset, bits 6:2 read 0, both reset outputs are 0 and `cpu_int_n` is 1.
- R7: The port is selected only when `iorq_n` is 0 and `io_addr` equals 16'h83AB. A write to any other address, or a write with `iorq_n` high, changes nothing.
- R8: A write loads `wdata` at the first rising edge where the write strobe is seen in `ST_IDLE`. Changes to `wdata` while the strobe is still held are ignored.
- R9: `rdata_oe` is 1 only while the port is selected with `rd_n` at 0. `rdata` then shows the register, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| io_addr | input | 16 | I/O address bus |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data toward the processor |
| rdata_oe | output | 1 | Read data drive enable |
| eth_int_n | input | 1 | Ethernet controller request, active low, asynchronous |
| usb_irq | input | 1 | USB controller request, active high, asynchronous |
| eth_rst_n | output | 1 | Ethernet controller reset, active low |
| usb_rst_n | output | 1 | USB controller reset, active low |
| cpu_int_n | output | 1 | Processor interrupt request (open-drain intent), active low |

## Verification
Read data and its enable are combinational from the bus inputs, so the bench samples them one time unit after it drives a read, with no clock edge in between. A committed write is visible on the reset outputs, the enables and `cpu_int_n` at the next falling edge after the rising edge that took it. A change on a request input is first seen two rising edges later. The bench therefore checks the old value after one edge and the new value after the second. The sweep waits two full cycles after setting the requests before it reads and compares.

// File: rtl/prirq_pkg.sv
package prirq_pkg;

    localparam int DATA_W = 8;
    localparam int N_SRC  = 2;

    // Field positions inside the port byte (software-visible layout)
    localparam int BIT_ETH_REQ = 0;
    localparam int BIT_USB_REQ = 1;
    localparam int BIT_ETH_EN  = 2;
    localparam int BIT_USB_EN  = 3;
    localparam int BIT_ETH_RST = 4;
    localparam int BIT_USB_RST = 5;
    localparam int BIT_DRV_EN  = 6;
    localparam int BIT_FLAG    = 7;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_WR_HOLD = 1'b1
    } bus_state_e;

endpackage

// File: rtl/pic_req_sync.sv
module pic_req_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pic_bus_fsm.sv
module pic_bus_fsm
    import prirq_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h83AB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              wr_commit,
    output logic              rd_sel
);

    bus_state_e state_q, state_d;
    logic       port_hit;
    logic       wr_hit;

    assign port_hit = !iorq_n && (io_addr == PORT_ADDR);
    assign wr_hit   = port_hit && !wr_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (wr_hit)  state_d = ST_WR_HOLD;
            ST_WR_HOLD: if (!wr_hit) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_commit = 1'b0;
        unique case (state_q)
            ST_IDLE:    wr_commit = wr_hit;
            ST_WR_HOLD: wr_commit = 1'b0;
            default:    wr_commit = 1'b0;
        endcase
        rd_sel = port_hit && !rd_n;
    end

    // R8: a held strobe never commits twice in a row
    a_r8_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R7: a commit only happens for a decoded I/O cycle at the port address
    a_r7_decode_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (!iorq_n && !wr_n && io_addr == PORT_ADDR));

endmodule

// File: rtl/pic_ctrl_reg.sv
module pic_ctrl_reg
    import prirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_SRC-1:0]  req,
    output logic [DATA_W-1:0] rd_word,
    output logic              eth_rst_n,
    output logic              usb_rst_n,
    output logic              irq_n
);

    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] rst_q;
    logic             drv_q;
    logic [N_SRC-1:0] masked;
    logic             flag;
    logic             unused_ro_bits;

    assign unused_ro_bits = ^{wr_data[BIT_FLAG], wr_data[BIT_USB_REQ], wr_data[BIT_ETH_REQ]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            rst_q <= '0;
            drv_q <= 1'b0;
        end else if (wr_commit) begin
            en_q  <= {wr_data[BIT_USB_EN],  wr_data[BIT_ETH_EN]};
            rst_q <= {wr_data[BIT_USB_RST], wr_data[BIT_ETH_RST]};
            drv_q <= wr_data[BIT_DRV_EN];
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_mask
        assign masked[g] = req[g] & en_q[g];
    end

    assign flag = |masked;

    always_comb begin
        rd_word              = '0;
        rd_word[BIT_ETH_REQ] = req[0];
        rd_word[BIT_USB_REQ] = req[1];
        rd_word[BIT_ETH_EN]  = en_q[0];
        rd_word[BIT_USB_EN]  = en_q[1];
        rd_word[BIT_ETH_RST] = rst_q[0];
        rd_word[BIT_USB_RST] = rst_q[1];
        rd_word[BIT_DRV_EN]  = drv_q;
        rd_word[BIT_FLAG]    = flag;
    end

    assign eth_rst_n = rst_q[0];
    assign usb_rst_n = rst_q[1];
    assign irq_n     = !(drv_q && flag);

    // R2: enables take the written bits on the commit edge
    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> en_q == {$past(wr_data[BIT_USB_EN]), $past(wr_data[BIT_ETH_EN])});

    // R5: reset outputs follow the written bits from the commit edge
    a_r5_reset_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> (eth_rst_n == $past(wr_data[BIT_ETH_RST]) &&
                       usb_rst_n == $past(wr_data[BIT_USB_RST])));

    // R4: the line is only pulled when external drive is enabled
    a_r4_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> drv_q);

    // R6: leaving reset, peripherals held in reset and line released
    a_r6_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!eth_rst_n && !usb_rst_n && irq_n));

endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl
    import prirq_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR   = 16'h83AB,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    input  logic              eth_int_n,
    input  logic              usb_irq,
    output logic              eth_rst_n,
    output logic              usb_rst_n,
    output logic              cpu_int_n
);

    logic              wr_commit;
    logic              rd_sel;
    logic [N_SRC-1:0]  req_raw;
    logic [N_SRC-1:0]  req_sync;
    logic [DATA_W-1:0] rd_word;

    assign req_raw = {usb_irq, !eth_int_n};

    pic_req_sync #(
        .WIDTH  (N_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_raw),
        .q     (req_sync)
    );

    pic_bus_fsm #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .iorq_n    (iorq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .wr_commit (wr_commit),
        .rd_sel    (rd_sel)
    );

    pic_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .wr_data   (wdata),
        .req       (req_sync),
        .rd_word   (rd_word),
        .eth_rst_n (eth_rst_n),
        .usb_rst_n (usb_rst_n),
        .irq_n     (cpu_int_n)
    );

    assign rdata_oe = rd_sel;
    assign rdata    = rd_sel ? rd_word : '0;

    // R9: no data drive without an active read strobe
    a_r9_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || iorq_n) |-> !rdata_oe);

endmodule

// File: tb/test_periph_irq_ctrl.sv
`timescale 1ns/1ps
module test_periph_irq_ctrl;

    localparam logic [15:0] PORT = 16'h83AB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic        eth_int_n = 1'b1, usb_irq = 1'b0;
    logic        eth_rst_n, usb_rst_n, cpu_int_n;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    periph_irq_ctrl i_periph_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe), .eth_int_n(eth_int_n), .usb_irq(usb_irq),
        .eth_rst_n(eth_rst_n), .usb_rst_n(usb_rst_n), .cpu_int_n(cpu_int_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // Call right after a falling edge: no rising edge inside
    task automatic read_now(input logic [15:0] a, output logic [7:0] d, output logic oe);
        io_addr = a; iorq_n = 1'b0; rd_n = 1'b0;
        #1;
        d = rdata; oe = rdata_oe;
        rd_n = 1'b1; iorq_n = 1'b1; io_addr = '0;
    endtask

    // Strobe held over two rising edges; data altered after the first
    task automatic bus_write(input logic [15:0] a, input logic [7:0] v, input logic io_n);
        @(negedge clk);
        io_addr = a; wdata = v; iorq_n = io_n; wr_n = 1'b0;
        @(negedge clk);
        wdata = ~v;
        @(negedge clk);
        wr_n = 1'b1; iorq_n = 1'b1; io_addr = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        read_now(PORT, d, oe);
        chk("R6 read after reset", {8'h0, d}, 16'h0000);
        chk("R6 eth_rst_n", {15'h0, eth_rst_n}, 16'h0);
        chk("R6 usb_rst_n", {15'h0, usb_rst_n}, 16'h0);
        chk("R6 cpu_int_n", {15'h0, cpu_int_n}, 16'h1);
        chk("R9 oe on read", {15'h0, oe}, 16'h1);

        // R1 latency on Ethernet request
        @(negedge clk);
        eth_int_n = 1'b0;
        read_now(PORT, d, oe);
        chk("R1 eth bit before edges", {15'h0, d[0]}, 16'h0);
        @(negedge clk);
        read_now(PORT, d, oe);
        chk("R1 eth bit after one edge", {15'h0, d[0]}, 16'h0);
        @(negedge clk);
        read_now(PORT, d, oe);
        chk("R1 eth bit after two edges", {15'h0, d[0]}, 16'h1);
        eth_int_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5 / R8: commit edge and ignored data change while held
        io_addr = PORT; iorq_n = 1'b0; wr_n = 1'b0; wdata = 8'h50;
        @(negedge clk);
        chk("R5 eth_rst_n one edge after strobe", {15'h0, eth_rst_n}, 16'h1);
        chk("R5 usb_rst_n one edge after strobe", {15'h0, usb_rst_n}, 16'h0);
        wdata = 8'h20;
        @(negedge clk);
        chk("R8 held strobe eth_rst_n", {15'h0, eth_rst_n}, 16'h1);
        chk("R8 held strobe usb_rst_n", {15'h0, usb_rst_n}, 16'h0);
        wr_n = 1'b1; iorq_n = 1'b1; io_addr = '0;
        @(negedge clk);
        read_now(PORT, d, oe);
        chk("R8 stored byte", {8'h0, d}, 16'h0050);

        // R7 decode: misses do not write
        bus_write(PORT, 8'h3C, 1'b0);
        bus_write(16'h83AA, 8'h00, 1'b0);
        bus_write(16'h03AB, 8'h00, 1'b0);
        bus_write(PORT, 8'h00, 1'b1);
        read_now(PORT, d, oe);
        chk("R7 register unchanged after misses", {8'h0, d}, 16'h003C);
        chk("R7 eth_rst_n kept", {15'h0, eth_rst_n}, 16'h1);
        chk("R7 usb_rst_n kept", {15'h0, usb_rst_n}, 16'h1);
        read_now(16'h83AA, d, oe);
        chk("R9 oe on wrong address", {15'h0, oe}, 16'h0);
        chk("R9 rdata zero on wrong address", {8'h0, d}, 16'h0000);

        // Exhaustive sweep: requests x enables x drive x resets
        for (int ir = 0; ir < 4; ir++) begin
            for (int en = 0; en < 4; en++) begin
                for (int dv = 0; dv < 2; dv++) begin
                    for (int rs = 0; rs < 4; rs++) begin
                        logic [1:0] ints, ena, rst2;
                        logic [7:0] wv;
                        logic       flag;
                        ints = 2'(ir); ena = 2'(en); rst2 = 2'(rs);
                        wv = {~ints[0], 1'(dv), rst2, ena, ~ints};
                        bus_write(PORT, wv, 1'b0);
                        eth_int_n = ~ints[0];
                        usb_irq   = ints[1];
                        @(negedge clk);
                        @(negedge clk);
                        flag = |(ints & ena);
                        read_now(PORT, d, oe);
                        chk("R1 request bits", {14'h0, d[1:0]}, {14'h0, ints});
                        chk("R2 control bits 6:2", {11'h0, d[6:2]}, {11'h0, 1'(dv), rst2, ena});
                        chk("R3 flag bit", {15'h0, d[7]}, {15'h0, flag});
                        chk("R4 cpu_int_n", {15'h0, cpu_int_n}, {15'h0, !(dv[0] && flag)});
                        chk("R5 reset outputs", {14'h0, usb_rst_n, eth_rst_n}, {14'h0, rst2});
                        chk("R9 oe", {15'h0, oe}, 16'h1);
                    end
                end
            end
        end

        report();
    end

endmodule